// File: doc/BRIEF.md
# Cacheable Store Backup Buffer

This block keeps a short, ordered log of allocating stores whose target address is cacheable. If software later invalidates a cache line without writing it back, those logged stores would be lost. The buffer replays them: an invalidate request looks for a logged store that falls in the same 32-byte line, drives it onto a single memory write strobe, and removes it from the log. A discard command drops the whole log, for example when the cached data has been written back by other means.

The log holds a fixed number of entries (8 by default), packed from slot 0 (oldest) upward with a valid bit per slot. Record, invalidate and discard may all be requested in the same clock. Each request completes in one clock, and every output is registered. The cacheability decision, tag lookup and memory timing belong to the surrounding logic.

Top module: `store_backup_buf`

## Requirements
- R1: A record request (`rec_valid`=1) stores an entry only when `rec_cacheable`=1. With `rec_cacheable`=0 the request changes no entry and raises no overflow.
- R2: Accepted records are appended after the newest valid entry, so entries stay in arrival order with the oldest first.
- R3: An invalidate compares addresses by line only. Bits [4:0] are ignored, so addresses that differ only in those bits match.
- R4: An invalidate that matches writes back the oldest matching entry. `mem_we` is high for exactly the cycle after the request, and `mem_addr`/`mem_data` carry that entry's stored address and data. Between writes, `mem_addr`/`mem_data` hold their last values.
- R5: The written-back entry is removed. All other entries keep their relative order, so a second invalidate of the same line writes the next-oldest match.
- R6: A discard (`discard`=1) empties the buffer. Discard takes priority: a record or invalidate in the same cycle is ignored, with no write and no overflow.
- R7: An invalidate that matches no valid entry produces no memory write.
- R8: The buffer holds DEPTH entries (8 by default). A cacheable record that finds no free slot is dropped, and `overflow` is high for the following cycle only.
- R9: When a record and an invalidate arrive in the same cycle, the invalidate searches the contents from before the record. Any removal happens first, so a record into a full buffer that loses an entry that cycle is accepted without overflow.
- R10: After a synchronous reset the buffer is empty and `mem_we`, `mem_addr`, `mem_data` and `overflow` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record request |
| rec_addr | input | 32 | Store address to record |
| rec_data | input | 32 | Store data to record |
| rec_cacheable | input | 1 | Record target is cacheable |
| inv_valid | input | 1 | Line-invalidate request |
| inv_addr | input | 32 | Address inside the line to invalidate |
| discard | input | 1 | Drop all entries |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 32 | Write-back address |
| mem_data | output | 32 | Write-back data |
| overflow | output | 1 | Record was dropped because the buffer was full |

## Verification
The bench builds the block with its default depth of 8 entries. It uses addresses drawn from only four lines with random low offsets. This makes several entries per line common, so oldest-first selection and order-preserving removal are exercised often. The small depth puts the full boundary within reach: the bench reaches it repeatedly, including same-cycle invalidate-plus-record at full occupancy and discards that collide with other requests.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int LINE_LSBS = 5;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sbb_entry_t;

    // Two addresses share a cache line when they agree above the line offset.
    function automatic logic same_line(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:LINE_LSBS] == b[ADDR_W-1:LINE_LSBS];
    endfunction

endpackage

// File: rtl/sbb_line_match.sv
module sbb_line_match
    import sbb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  sbb_entry_t        slots [DEPTH],
    input  logic [ADDR_W-1:0] req_addr,
    output logic [DEPTH-1:0]  match
);

    // One comparator per slot; an empty slot never matches.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = slots[i].valid && same_line(slots[i].addr, req_addr);
    end

endmodule

// File: rtl/sbb_first_pick.sv
module sbb_first_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // The lowest set bit wins: slot 0 holds the oldest entry.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sbb_entry_store.sv
module sbb_entry_store
    import sbb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [DEPTH-1:0] shift_mask,
    input  logic [DEPTH-1:0] wr_sel,
    input  sbb_entry_t       wr_entry,
    output sbb_entry_t       slots [DEPTH]
);

    // Each slot either keeps its value, takes the value from the slot above
    // (closing the gap after a removal), or takes a new record. A new record
    // lands in the first free slot after any same-cycle shift.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        sbb_entry_t above;
        sbb_entry_t nxt;

        if (i == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = slots[i+1];
        end

        always_comb begin
            nxt = shift_mask[i] ? above : slots[i];
            if (wr_sel[i]) begin
                nxt = wr_entry;
            end
            if (clear) begin
                nxt = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else begin
                slots[i] <= nxt;
            end
        end
    end

endmodule

// File: rtl/store_backup_buf.sv
module store_backup_buf
    import sbb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [DATA_W-1:0] rec_data,
    input  logic              rec_cacheable,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              discard,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              overflow
);

    sbb_entry_t       slots [DEPTH];
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] match;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] occ_after;
    logic             inv_do;
    logic             rec_want;
    logic             rec_take;
    logic             rec_drop;
    logic [DEPTH-1:0] shift_mask;
    logic [DEPTH-1:0] wr_sel;
    sbb_entry_t       new_entry;

    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign valid_vec[i] = slots[i].valid;
    end

    sbb_line_match #(.DEPTH(DEPTH)) u_match (
        .slots    (slots),
        .req_addr (inv_addr),
        .match    (match)
    );

    sbb_first_pick #(.DEPTH(DEPTH)) u_pick (
        .req (match),
        .hit (hit),
        .idx (hit_idx)
    );

    // Occupancy is the number of valid slots.
    always_comb begin
        occ = '0;
        for (int i = 0; i < DEPTH; i++) begin
            occ = occ + CNT_W'(valid_vec[i]);
        end
    end

    // Discard overrides the other requests. An invalidate removes before a
    // record appends, so free space is judged after the removal.
    assign inv_do    = inv_valid && !discard && hit;
    assign occ_after = occ - CNT_W'(inv_do);
    assign rec_want  = rec_valid && rec_cacheable && !discard;
    assign rec_take  = rec_want && (occ_after < CNT_W'(DEPTH));
    assign rec_drop  = rec_want && (occ_after == CNT_W'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_ctl
        assign shift_mask[i] = inv_do && (IDX_W'(i) >= hit_idx);
        assign wr_sel[i]     = rec_take && (occ_after == CNT_W'(i));
    end

    assign new_entry = '{valid: 1'b1, addr: rec_addr, data: rec_data};

    sbb_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear      (discard),
        .shift_mask (shift_mask),
        .wr_sel     (wr_sel),
        .wr_entry   (new_entry),
        .slots      (slots)
    );

    // Registered write-back port and overflow pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            overflow <= 1'b0;
        end else begin
            mem_we   <= inv_do;
            overflow <= rec_drop;
            if (inv_do) begin
                mem_addr <= slots[hit_idx].addr;
                mem_data <= slots[hit_idx].data;
            end
        end
    end

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker
    import sbb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rec_valid,
    input logic              rec_cacheable,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_addr,
    input logic              discard,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              overflow,
    input logic [DEPTH-1:0]  slot_valid
);

    AST_PACKED_ORDER: assert property (@(posedge clk) disable iff (rst)
        (slot_valid & DEPTH'(slot_valid + 1'b1)) == '0); // R2

    AST_IGNORE_UNCACHED: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_cacheable && !inv_valid && !discard)
        |=> $stable(slot_valid)); // R1

    AST_WRITE_SAME_LINE: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !discard) |=>
        (!mem_we || mem_addr[ADDR_W-1:LINE_LSBS] == $past(inv_addr[ADDR_W-1:LINE_LSBS]))); // R3

    AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !(inv_valid && !discard) |=> !mem_we); // R4

    AST_DISCARD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        discard |=> (slot_valid == '0 && !mem_we && !overflow)); // R6

    AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (slot_valid == '0) |=> !mem_we); // R7

    AST_OVERFLOW_FULL: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_cacheable && !discard && !inv_valid && (&slot_valid))
        |=> (overflow && $stable(slot_valid))); // R8

    AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !(rec_valid && rec_cacheable) |=> !overflow); // R8

endmodule

bind store_backup_buf sbb_checker #(.DEPTH(DEPTH)) u_sbb_checker (
    .clk           (clk),
    .rst           (rst),
    .rec_valid     (rec_valid),
    .rec_cacheable (rec_cacheable),
    .inv_valid     (inv_valid),
    .inv_addr      (inv_addr),
    .discard       (discard),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .overflow      (overflow),
    .slot_valid    (valid_vec)
);

// File: tb/test_store_backup_buf.sv
`timescale 1ns/1ps
module test_store_backup_buf;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid = 1'b0;
    logic [31:0] rec_addr = '0;
    logic [31:0] rec_data = '0;
    logic        rec_cacheable = 1'b0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_addr = '0;
    logic        discard = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        overflow;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    store_backup_buf #(.DEPTH(DEPTH)) i_store_backup_buf (
        .clk           (clk),
        .rst           (rst),
        .rec_valid     (rec_valid),
        .rec_addr      (rec_addr),
        .rec_data      (rec_data),
        .rec_cacheable (rec_cacheable),
        .inv_valid     (inv_valid),
        .inv_addr      (inv_addr),
        .discard       (discard),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_data      (mem_data),
        .overflow      (overflow)
    );

    // Behavioural reference: a queue of (address, data), oldest at index 0.
    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
    } ref_t;

    ref_t        mq[$];
    logic        e_we  = 1'b0;
    logic [31:0] e_adr = '0;
    logic [31:0] e_dat = '0;
    logic        e_ovf = 1'b0;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h @%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check(mem_we === e_we,    tag, "mem_we",   32'(mem_we),   32'(e_we));
        check(mem_addr === e_adr, tag, "mem_addr", mem_addr,      e_adr);
        check(mem_data === e_dat, tag, "mem_data", mem_data,      e_dat);
        check(overflow === e_ovf, tag, "overflow", 32'(overflow), 32'(e_ovf));
    endtask

    // Drive one cycle of requests (called just after a falling edge), update
    // the reference, then compare at the next falling edge.
    task automatic cyc(input logic rv, input logic [31:0] ra, input logic [31:0] rd,
                       input logic rc, input logic iv, input logic [31:0] ia,
                       input logic dc, input string tag);
        rec_valid = rv; rec_addr = ra; rec_data = rd; rec_cacheable = rc;
        inv_valid = iv; inv_addr = ia; discard = dc;
        e_we = 1'b0;
        e_ovf = 1'b0;
        if (dc) begin
            mq.delete();
        end else begin
            if (iv) begin
                for (int k = 0; k < mq.size(); k++) begin
                    if (mq[k].a[31:5] == ia[31:5]) begin
                        e_we  = 1'b1;
                        e_adr = mq[k].a;
                        e_dat = mq[k].d;
                        mq.delete(k);
                        break;
                    end
                end
            end
            if (rv && rc) begin
                if (mq.size() < DEPTH) mq.push_back('{a: ra, d: rd});
                else e_ovf = 1'b1;
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic rec(input logic [31:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 1'b1, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic inv(input logic [31:0] a, input string tag);
        cyc(1'b0, '0, '0, 1'b0, 1'b1, a, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R10");           // outputs zero during reset
        rst = 1'b0;
        idle("R10");

        // R1: uncached record ignored, later invalidate of its line misses
        cyc(1'b1, 32'h0000_1004, 32'hAAAA_0001, 1'b0, 1'b0, '0, 1'b0, "R1");
        inv(32'h0000_1000, "R1");
        idle("R7");

        // R2/R4/R5: three stores in one line, interleaved with another line
        rec(32'h0000_2000, 32'h1111_0000, "R2");
        rec(32'h0000_3008, 32'h2222_0000, "R2");
        rec(32'h0000_2014, 32'h1111_0001, "R2");
        rec(32'h0000_201C, 32'h1111_0002, "R2");
        // R3: request offset differs in bits [4:0]
        inv(32'h0000_201F, "R3");
        inv(32'h0000_2001, "R5");
        check(mem_data === 32'h1111_0001, "R5", "second oldest", mem_data, 32'h1111_0001);
        idle("R4");
        inv(32'h0000_2000, "R5");
        inv(32'h0000_2000, "R7");
        // R3: next line up must not match
        inv(32'h0000_3020, "R3");
        inv(32'h0000_3000, "R4");
        check(mem_addr === 32'h0000_3008, "R4", "stored address", mem_addr, 32'h0000_3008);
        inv(32'h0000_3000, "R7");

        // R8: fill to depth, then one more
        for (int k = 0; k < DEPTH; k++) rec(32'h0000_4000 + 32'(k * 32), 32'h5000 + 32'(k), "R8");
        rec(32'h0000_9000, 32'hDEAD_0000, "R8");
        check(overflow === 1'b1, "R8", "overflow raised", 32'(overflow), 1);
        idle("R8");
        check(overflow === 1'b0, "R8", "overflow pulse", 32'(overflow), 0);
        inv(32'h0000_9000, "R8");

        // R9: full buffer, invalidate plus record same cycle
        cyc(1'b1, 32'h0000_A000, 32'hBEEF_0000, 1'b1, 1'b1, 32'h0000_4020, 1'b0, "R9");
        check(overflow === 1'b0, "R9", "no overflow", 32'(overflow), 0);
        // R9: invalidate searches the old contents, not the same-cycle record
        cyc(1'b1, 32'h0000_B000, 32'hBEEF_0001, 1'b1, 1'b1, 32'h0000_B000, 1'b0, "R9");
        inv(32'h0000_A000, "R9");
        inv(32'h0000_4000, "R5");

        // R6: discard with colliding record and invalidate
        cyc(1'b1, 32'h0000_C000, 32'h7777, 1'b1, 1'b1, 32'h0000_4040, 1'b1, "R6");
        check(mem_we === 1'b0, "R6", "no write on discard", 32'(mem_we), 0);
        inv(32'h0000_4040, "R6");
        inv(32'h0000_C000, "R6");
        inv(32'h0000_B000, "R6");

        // Random mix over four lines
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ra, ia;
            ra = {24'h0, 1'b0, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31))};
            ia = {24'h0, 1'b0, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31))};
            cyc(1'($urandom_range(0, 99) < 60), ra, $urandom(),
                1'($urandom_range(0, 99) < 80),
                1'($urandom_range(0, 99) < 40), ia,
                1'($urandom_range(0, 99) < 3), "R2");
        end

        summary();
        $finish;
    end

endmodule